// File: doc/BRIEF.md
# Self-timed page operation sequencer

This block carries out the internal, self-timed work of a page-organised serial flash once a command has been fully shifted in and chip select has gone high. The serial front end hands it one opcode and one page number as a single-cycle pulse. The sequencer then moves bytes between the main page array and the single page-sized data buffer, both reached through simple synchronous byte-wide ports with one cycle of read latency. It can copy a page into the buffer, compare a page with the buffer, erase a page or an aligned group of pages to all ones, and program the buffer into a page. It also runs the compound forms: erase then program, and copy then erase then program back.

Each phase walks the bytes of its page or group and then waits a settle time set by a parameter. The active-low ready/busy output stays low from acceptance until the last phase finishes. An 8-bit status byte reports readiness, a fixed density code and the result of the most recent compare. A write-protect input, sampled when a command is accepted, blocks any command that would alter the lower half of the page space. Such a command finishes at once, leaves the block ready and changes nothing.

Top module: `page_seq`

## Requirements
- R1: The status byte is {ready, compare_miss, 3'b001, 3'b000}, with bit 7 the ready flag, bit 6 the compare result, bits 5..3 fixed at 001 and bits 2..0 at 000. After reset it reads 8'h88.
- R2: Opcodes 53h, 60h, 83h, 82h, 88h, 81h, 50h and 58h start an operation when they are accepted while ready. rdy_busy_n and status bit 7 go low in the cycle after acceptance and stay low for the whole operation. The busy time is the sum over the phases of a phase term. Copy and compare each take PAGE_BYTES+1+XFER_CYC. Page erase takes PAGE_BYTES+ERASE_CYC. Program takes PAGE_BYTES+1+PROG_CYC. Group erase takes BLK_PAGES*PAGE_BYTES+BLK_CYC. Any other opcode leaves the block ready.
- R3: Opcode 53h copies the addressed page into the buffer and leaves the page array unchanged.
- R4: Opcode 60h sets status bit 6 to 0 when every byte of the page equals the buffer, and to 1 when any bit differs. Bit 6 keeps that value through all other commands until the next compare.
- R5: Opcode 81h sets every byte of the addressed page to FFh and no other page changes.
- R6: Opcodes 83h and 82h erase the addressed page and then program it, so that afterwards it equals the buffer whatever it held before.
- R7: Opcode 88h programs without erasing, so each byte of the page becomes the old byte AND the buffer byte.
- R8: Opcode 50h sets to FFh all BLK_PAGES pages whose page number shares the address bits above log2(BLK_PAGES) with the given page. No page outside that group changes.
- R9: Opcode 58h copies the page into the buffer, erases it, and programs it back, so that the page keeps its content and the buffer equals it.
- R10: When wp_n is low at acceptance, the opcodes 83h, 82h, 88h, 81h, 50h and 58h aimed at a page below PAGE_COUNT/2 change neither memory nor buffer, and the block stays ready. The same opcodes aimed at the upper half, and 53h or 60h on any page, run normally.
- R11: A low rst_n aborts any operation and holds the block ready with status 8'h88 for as long as it stays low. After release the block accepts new commands.
- R12: A command pulse that arrives while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset and abort |
| cmd_valid | input | 1 | Single-cycle pulse: a command has finished loading |
| cmd_op | input | 8 | Opcode of the command |
| cmd_page | input | PAGE_AW | Page number of the command |
| wp_n | input | 1 | Active-low write protection for the lower half of the pages |
| mem_re | output | 1 | Page array read enable |
| mem_raddr | output | MEM_AW | Page array read byte address (page*PAGE_BYTES+byte) |
| mem_rdata | input | 8 | Page array read data, one cycle after mem_re |
| mem_we | output | 1 | Page array write enable |
| mem_waddr | output | MEM_AW | Page array write byte address |
| mem_wdata | output | 8 | Page array write data |
| buf_addr | output | BUF_AW | Buffer byte address, shared by reads and writes |
| buf_we | output | 1 | Buffer write enable; when low the buffer reads buf_addr |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data, one cycle after the address |
| status | output | 8 | Status byte |
| rdy_busy_n | output | 1 | Ready (1) or busy (0) |

## Verification
The assertions take cmd_valid to be a one-cycle pulse with cmd_op, cmd_page and wp_n valid in that cycle. They take both memories to return read data exactly one cycle after the address. The stimulus raises cmd_valid for a single cycle at a falling clock edge and models both memories in the bench with a one-cycle registered read. Write protection is changed only while the block is idle. The bench checks every command's effect on the whole array, the buffer, the status byte and the exact busy length against its own model. It also drives a command into a busy block and aborts a compound operation with reset.

// File: rtl/pgseq_pkg.sv
`timescale 1ns/1ps
package pgseq_pkg;

   typedef enum logic [2:0] {
      PH_NONE     = 3'd0,
      PH_FETCH    = 3'd1,
      PH_MATCH    = 3'd2,
      PH_WIPE     = 3'd3,
      PH_WIPE_BLK = 3'd4,
      PH_BURN     = 3'd5
   } phase_e;

   typedef struct packed {
      phase_e first;
      phase_e second;
      phase_e third;
      logic   alters;
   } plan_t;

   localparam logic [7:0] OP_FETCH     = 8'h53;
   localparam logic [7:0] OP_MATCH     = 8'h60;
   localparam logic [7:0] OP_WIPE_BURN = 8'h83;
   localparam logic [7:0] OP_LOAD_BURN = 8'h82;
   localparam logic [7:0] OP_BURN      = 8'h88;
   localparam logic [7:0] OP_WIPE      = 8'h81;
   localparam logic [7:0] OP_WIPE_BLK  = 8'h50;
   localparam logic [7:0] OP_REFRESH   = 8'h58;

   function automatic plan_t plan_of(input logic [7:0] op);
      plan_t p;
      p = '{first: PH_NONE, second: PH_NONE, third: PH_NONE, alters: 1'b0};
      case (op)
         OP_FETCH:     p.first = PH_FETCH;
         OP_MATCH:     p.first = PH_MATCH;
         OP_WIPE_BURN,
         OP_LOAD_BURN: begin
            p.first  = PH_WIPE;
            p.second = PH_BURN;
            p.alters = 1'b1;
         end
         OP_BURN: begin
            p.first  = PH_BURN;
            p.alters = 1'b1;
         end
         OP_WIPE: begin
            p.first  = PH_WIPE;
            p.alters = 1'b1;
         end
         OP_WIPE_BLK: begin
            p.first  = PH_WIPE_BLK;
            p.alters = 1'b1;
         end
         OP_REFRESH: begin
            p.first  = PH_FETCH;
            p.second = PH_WIPE;
            p.third  = PH_BURN;
            p.alters = 1'b1;
         end
         default: ;
      endcase
      return p;
   endfunction

   function automatic logic is_piped(input phase_e ph);
      return (ph == PH_FETCH) || (ph == PH_MATCH) || (ph == PH_BURN);
   endfunction

endpackage

// File: rtl/pgseq_decode.sv
`timescale 1ns/1ps
module pgseq_decode
   import pgseq_pkg::*;
#(
   parameter int PAGE_AW    = 9,
   parameter int PROT_LIMIT = 256
) (
   input  logic [7:0]         op,
   input  logic [PAGE_AW-1:0] page,
   input  logic               wp_n,
   output plan_t              plan,
   output logic               go
);

   logic guarded;

   always_comb begin
      plan    = plan_of(op);
      guarded = !wp_n && plan.alters && (page < PAGE_AW'(PROT_LIMIT));
      go      = (plan.first != PH_NONE) && !guarded;
   end

endmodule

// File: rtl/pgseq_steer.sv
`timescale 1ns/1ps
module pgseq_steer
   import pgseq_pkg::*;
#(
   parameter int MEM_AW   = 18,
   parameter int BUF_AW   = 9,
   parameter int CNT_W    = 12,
   parameter bit PROG_AND = 1'b1
) (
   input  logic              walking,
   input  phase_e            phase,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              in_span,
   input  logic [MEM_AW-1:0] base,
   input  logic [7:0]        mem_rdata,
   input  logic [7:0]        buf_rdata,
   output logic              mem_re,
   output logic [MEM_AW-1:0] mem_raddr,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_waddr,
   output logic [7:0]        mem_wdata,
   output logic [BUF_AW-1:0] buf_addr,
   output logic              buf_we,
   output logic [7:0]        buf_wdata,
   output logic              miss_now
);

   logic             has_prev;
   logic [CNT_W-1:0] cnt_m1;
   logic             wiping;
   logic [7:0]       burn_byte;

   // Program without erase either merges into the old byte (flash-like)
   // or overwrites it.
   generate
      if (PROG_AND) begin : g_merge
         assign burn_byte = mem_rdata & buf_rdata;
      end else begin : g_overwrite
         assign burn_byte = buf_rdata;
      end
   endgenerate

   always_comb begin
      has_prev  = (cnt != '0);
      cnt_m1    = cnt - 1'b1;
      wiping    = (phase == PH_WIPE) || (phase == PH_WIPE_BLK);

      mem_re    = walking && is_piped(phase) && in_span;
      mem_raddr = base + MEM_AW'(cnt);

      mem_we    = walking && ((wiping && in_span) || ((phase == PH_BURN) && has_prev));
      mem_waddr = wiping ? (base + MEM_AW'(cnt)) : (base + MEM_AW'(cnt_m1));
      mem_wdata = wiping ? 8'hFF : burn_byte;

      buf_addr  = (phase == PH_FETCH) ? BUF_AW'(cnt_m1) : BUF_AW'(cnt);
      buf_we    = walking && (phase == PH_FETCH) && has_prev;
      buf_wdata = mem_rdata;

      miss_now  = walking && (phase == PH_MATCH) && has_prev && (mem_rdata != buf_rdata);
   end

endmodule

// File: rtl/page_seq.sv
`timescale 1ns/1ps
module page_seq
   import pgseq_pkg::*;
#(
   parameter int PAGE_BYTES = 264,
   parameter int PAGE_COUNT = 512,
   parameter int BLK_PAGES  = 8,
   parameter int XFER_CYC   = 4,
   parameter int ERASE_CYC  = 6,
   parameter int PROG_CYC   = 6,
   parameter int BLK_CYC    = 8,
   parameter bit PROG_AND   = 1'b1,
   localparam int PAGE_AW   = $clog2(PAGE_COUNT),
   localparam int BUF_AW    = $clog2(PAGE_BYTES),
   localparam int MEM_AW    = $clog2(PAGE_COUNT * PAGE_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [7:0]         cmd_op,
   input  logic [PAGE_AW-1:0] cmd_page,
   input  logic               wp_n,
   output logic               mem_re,
   output logic [MEM_AW-1:0]  mem_raddr,
   input  logic [7:0]         mem_rdata,
   output logic               mem_we,
   output logic [MEM_AW-1:0]  mem_waddr,
   output logic [7:0]         mem_wdata,
   output logic [BUF_AW-1:0]  buf_addr,
   output logic               buf_we,
   output logic [7:0]         buf_wdata,
   input  logic [7:0]         buf_rdata,
   output logic [7:0]         status,
   output logic               rdy_busy_n
);

   localparam int SPAN       = BLK_PAGES * PAGE_BYTES;
   localparam int CNT_W      = $clog2(SPAN + 2);
   localparam int PROT_LIMIT = PAGE_COUNT / 2;
   localparam int WMAX_A     = (XFER_CYC > ERASE_CYC) ? XFER_CYC : ERASE_CYC;
   localparam int WMAX_B     = (PROG_CYC > BLK_CYC) ? PROG_CYC : BLK_CYC;
   localparam int WMAX       = (WMAX_A > WMAX_B) ? WMAX_A : WMAX_B;
   localparam int WAIT_W     = $clog2(WMAX + 1);

   generate
      if (BLK_PAGES < 2 || (BLK_PAGES & (BLK_PAGES - 1)) != 0) begin : g_bad_blk
         $error("BLK_PAGES must be a power of two of at least 2");
      end
      if ((PAGE_COUNT & (PAGE_COUNT - 1)) != 0 || PROT_LIMIT % BLK_PAGES != 0) begin : g_bad_cnt
         $error("PAGE_COUNT must be a power of two holding whole groups in each half");
      end
      if (PAGE_BYTES < 2) begin : g_bad_bytes
         $error("PAGE_BYTES must be at least 2");
      end
      if (XFER_CYC < 1 || ERASE_CYC < 1 || PROG_CYC < 1 || BLK_CYC < 1) begin : g_bad_wait
         $error("every settle time must be at least one cycle");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_SETTLE} st_e;

   st_e                st_q;
   phase_e             cur_q, nxt1_q, nxt2_q;
   logic [MEM_AW-1:0]  base_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [WAIT_W-1:0]  wcnt_q;
   logic               miss_q;
   logic               cmp_q;

   plan_t              plan;
   logic               dec_go;
   logic               accept;
   logic [PAGE_AW-1:0] blk_page;
   logic [MEM_AW-1:0]  pg_base, blk_base;
   logic [CNT_W-1:0]   span_len, last_cnt;
   logic [WAIT_W-1:0]  wait_len;
   logic               walking, in_span, miss_now;

   pgseq_decode #(
      .PAGE_AW    (PAGE_AW),
      .PROT_LIMIT (PROT_LIMIT)
   ) u_decode (
      .op   (cmd_op),
      .page (cmd_page),
      .wp_n (wp_n),
      .plan (plan),
      .go   (dec_go)
   );

   always_comb begin
      accept   = (st_q == ST_IDLE) && cmd_valid && dec_go;
      blk_page = cmd_page & ~PAGE_AW'(BLK_PAGES - 1);
      pg_base  = MEM_AW'(cmd_page) * MEM_AW'(PAGE_BYTES);
      blk_base = MEM_AW'(blk_page) * MEM_AW'(PAGE_BYTES);
      span_len = (cur_q == PH_WIPE_BLK) ? CNT_W'(SPAN) : CNT_W'(PAGE_BYTES);
      last_cnt = span_len + (is_piped(cur_q) ? CNT_W'(1) : CNT_W'(0)) - CNT_W'(1);
      walking  = (st_q == ST_WALK);
      in_span  = (cnt_q < span_len);
      case (cur_q)
         PH_FETCH, PH_MATCH: wait_len = WAIT_W'(XFER_CYC);
         PH_WIPE:            wait_len = WAIT_W'(ERASE_CYC);
         PH_WIPE_BLK:        wait_len = WAIT_W'(BLK_CYC);
         default:            wait_len = WAIT_W'(PROG_CYC);
      endcase
   end

   pgseq_steer #(
      .MEM_AW   (MEM_AW),
      .BUF_AW   (BUF_AW),
      .CNT_W    (CNT_W),
      .PROG_AND (PROG_AND)
   ) u_steer (
      .walking   (walking),
      .phase     (cur_q),
      .cnt       (cnt_q),
      .in_span   (in_span),
      .base      (base_q),
      .mem_rdata (mem_rdata),
      .buf_rdata (buf_rdata),
      .mem_re    (mem_re),
      .mem_raddr (mem_raddr),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .mem_wdata (mem_wdata),
      .buf_addr  (buf_addr),
      .buf_we    (buf_we),
      .buf_wdata (buf_wdata),
      .miss_now  (miss_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cur_q  <= PH_NONE;
         nxt1_q <= PH_NONE;
         nxt2_q <= PH_NONE;
         base_q <= '0;
         cnt_q  <= '0;
         wcnt_q <= '0;
         miss_q <= 1'b0;
         cmp_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  cur_q  <= plan.first;
                  nxt1_q <= plan.second;
                  nxt2_q <= plan.third;
                  base_q <= (plan.first == PH_WIPE_BLK) ? blk_base : pg_base;
                  cnt_q  <= '0;
                  miss_q <= 1'b0;
                  st_q   <= ST_WALK;
               end
            end
            ST_WALK: begin
               if (miss_now) begin
                  miss_q <= 1'b1;
               end
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == last_cnt) begin
                  wcnt_q <= wait_len - 1'b1;
                  st_q   <= ST_SETTLE;
                  if (cur_q == PH_MATCH) begin
                     cmp_q <= miss_q | miss_now;
                  end
               end
            end
            default: begin
               if (wcnt_q == '0) begin
                  cur_q  <= nxt1_q;
                  nxt1_q <= nxt2_q;
                  nxt2_q <= PH_NONE;
                  cnt_q  <= '0;
                  st_q   <= (nxt1_q == PH_NONE) ? ST_IDLE : ST_WALK;
               end else begin
                  wcnt_q <= wcnt_q - 1'b1;
               end
            end
         endcase
      end
   end

   assign rdy_busy_n = (st_q == ST_IDLE);
   assign status     = {rdy_busy_n, cmp_q, 3'b001, 3'b000};

endmodule

// File: rtl/page_seq_chk.sv
`timescale 1ns/1ps
module page_seq_chk #(
   parameter int PAGE_AW    = 9,
   parameter int PROT_LIMIT = 256
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic [7:0]         cmd_op,
   input logic [PAGE_AW-1:0] cmd_page,
   input logic               wp_n,
   input logic               mem_re,
   input logic               mem_we,
   input logic               buf_we,
   input logic [7:0]         status,
   input logic               rdy_busy_n
);

   assert_status_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (status[5:3] == 3'b001) && (status[2:0] == 3'b000));

   assert_ready_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
      status[7] == rdy_busy_n);

   assert_fetch_goes_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_busy_n && cmd_valid && cmd_op == 8'h53) |=> !rdy_busy_n);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_busy_n |-> (!mem_we && !buf_we && !mem_re));

   assert_fetch_no_mem_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> !mem_we);

   assert_cmp_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_busy_n && $past(rdy_busy_n)) |-> $stable(status[6]));

   assert_guard_stays_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_busy_n && cmd_valid && !wp_n && (cmd_page < PAGE_AW'(PROT_LIMIT)) &&
       (cmd_op == 8'h81 || cmd_op == 8'h83 || cmd_op == 8'h50)) |=> rdy_busy_n);

   assert_ready_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> rdy_busy_n);

endmodule

bind page_seq page_seq_chk #(
   .PAGE_AW    (PAGE_AW),
   .PROT_LIMIT (PAGE_COUNT / 2)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .cmd_page   (cmd_page),
   .wp_n       (wp_n),
   .mem_re     (mem_re),
   .mem_we     (mem_we),
   .buf_we     (buf_we),
   .status     (status),
   .rdy_busy_n (rdy_busy_n)
);

// File: tb/page_seq_test.sv
`timescale 1ns/1ps
module page_seq_test;

   localparam int PB   = 16;
   localparam int PC   = 32;
   localparam int BLK  = 8;
   localparam int HALF = PC / 2;
   localparam int MEMN = PB * PC;
   localparam int XC   = 3;
   localparam int EC   = 5;
   localparam int PCY  = 4;
   localparam int BC   = 6;
   localparam int PAW  = $clog2(PC);
   localparam int BAW  = $clog2(PB);
   localparam int MAW  = $clog2(MEMN);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cmd_valid = 1'b0;
   logic [7:0]     cmd_op = 8'h00;
   logic [PAW-1:0] cmd_page = '0;
   logic           wp_n = 1'b1;
   logic           mem_re, mem_we, buf_we, rdy_busy_n;
   logic [MAW-1:0] mem_raddr, mem_waddr;
   logic [7:0]     mem_rdata, mem_wdata, buf_wdata, buf_rdata, status;
   logic [BAW-1:0] buf_addr;

   logic           ld_mem = 1'b0;
   logic           ld_buf = 1'b0;
   logic [7:0]     ld_seed = 8'h00;

   logic [7:0] mem_m [MEMN];
   logic [7:0] buf_m [PB];
   logic [7:0] exp_mem [MEMN];
   logic [7:0] exp_buf [PB];
   logic       exp_cmp;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   page_seq #(
      .PAGE_BYTES (PB), .PAGE_COUNT (PC), .BLK_PAGES (BLK),
      .XFER_CYC (XC), .ERASE_CYC (EC), .PROG_CYC (PCY), .BLK_CYC (BC)
   ) uut (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
      .cmd_page (cmd_page), .wp_n (wp_n),
      .mem_re (mem_re), .mem_raddr (mem_raddr), .mem_rdata (mem_rdata),
      .mem_we (mem_we), .mem_waddr (mem_waddr), .mem_wdata (mem_wdata),
      .buf_addr (buf_addr), .buf_we (buf_we), .buf_wdata (buf_wdata),
      .buf_rdata (buf_rdata), .status (status), .rdy_busy_n (rdy_busy_n)
   );

   function automatic logic [7:0] pat_mem(input int a);
      return 8'((a * 37 + 5) & 255);
   endfunction

   function automatic logic [7:0] pat_buf(input int i, input logic [7:0] s);
      return 8'((i * 13) & 255) ^ s;
   endfunction

   // Memory models: one-cycle registered reads
   always @(posedge clk) begin
      if (ld_mem) begin
         for (int a = 0; a < MEMN; a++) mem_m[a] <= pat_mem(a);
      end else begin
         if (mem_we) mem_m[mem_waddr] <= mem_wdata;
         if (mem_re) mem_rdata <= mem_m[mem_raddr];
      end
      if (ld_buf) begin
         for (int i = 0; i < PB; i++) buf_m[i] <= pat_buf(i, ld_seed);
      end else if (buf_we) begin
         buf_m[buf_addr] <= buf_wdata;
      end else begin
         buf_rdata <= buf_m[buf_addr];
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic init_mem();
      @(negedge clk) ld_mem = 1'b1;
      @(negedge clk) ld_mem = 1'b0;
      for (int a = 0; a < MEMN; a++) exp_mem[a] = pat_mem(a);
   endtask

   task automatic load_buf(input logic [7:0] s);
      @(negedge clk) begin ld_buf = 1'b1; ld_seed = s; end
      @(negedge clk) ld_buf = 1'b0;
      for (int i = 0; i < PB; i++) exp_buf[i] = pat_buf(i, s);
   endtask

   function automatic int exp_cycles(input logic [7:0] op);
      int f, w, b, p;
      f = PB + 1 + XC; w = PB + EC; b = BLK * PB + BC; p = PB + 1 + PCY;
      case (op)
         8'h53, 8'h60: return f;
         8'h83, 8'h82: return w + p;
         8'h88:        return p;
         8'h81:        return w;
         8'h50:        return b;
         8'h58:        return f + w + p;
         default:      return 0;
      endcase
   endfunction

   // Reference model of the requirements; returns 1 when the command runs
   function automatic bit ref_apply(input logic [7:0] op, input int page, input logic wp);
      bit alters, busyop;
      int pb, bb;
      alters = (op == 8'h83) || (op == 8'h82) || (op == 8'h88) ||
               (op == 8'h81) || (op == 8'h50) || (op == 8'h58);
      busyop = alters || (op == 8'h53) || (op == 8'h60);
      if (!busyop || (alters && !wp && page < HALF)) return 1'b0;
      pb = page * PB;
      case (op)
         8'h53, 8'h58: for (int i = 0; i < PB; i++) exp_buf[i] = exp_mem[pb + i];
         8'h60: begin
            exp_cmp = 1'b0;
            for (int i = 0; i < PB; i++) if (exp_mem[pb + i] != exp_buf[i]) exp_cmp = 1'b1;
         end
         8'h81: for (int i = 0; i < PB; i++) exp_mem[pb + i] = 8'hFF;
         8'h83, 8'h82: for (int i = 0; i < PB; i++) exp_mem[pb + i] = exp_buf[i];
         8'h88: for (int i = 0; i < PB; i++) exp_mem[pb + i] = exp_mem[pb + i] & exp_buf[i];
         8'h50: begin
            bb = (page / BLK) * BLK * PB;
            for (int i = 0; i < BLK * PB; i++) exp_mem[bb + i] = 8'hFF;
         end
         default: ;
      endcase
      return 1'b1;
   endfunction

   task automatic pulse_cmd(input logic [7:0] op, input int page, input logic wp);
      @(negedge clk) begin
         cmd_valid = 1'b1; cmd_op = op; cmd_page = PAW'(page); wp_n = wp;
      end
      @(negedge clk) cmd_valid = 1'b0;
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!rdy_busy_n && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic check_arrays(input string tag);
      int bad, first_a;
      bad = 0; first_a = -1;
      for (int a = 0; a < MEMN; a++)
         if (mem_m[a] !== exp_mem[a]) begin bad++; if (first_a < 0) first_a = a; end
      check(bad == 0, {tag, " page array"}, (first_a < 0) ? 0 : int'(mem_m[first_a]),
            (first_a < 0) ? 0 : int'(exp_mem[first_a]));
      bad = 0; first_a = -1;
      for (int i = 0; i < PB; i++)
         if (buf_m[i] !== exp_buf[i]) begin bad++; if (first_a < 0) first_a = i; end
      check(bad == 0, {tag, " buffer"}, (first_a < 0) ? 0 : int'(buf_m[first_a]),
            (first_a < 0) ? 0 : int'(exp_buf[first_a]));
   endtask

   typedef struct packed {
      logic [7:0] op;
      logic [7:0] page;
      logic       wp;
      logic       ld;
      logic [7:0] seed;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{8'h53, 8'd20, 1'b1, 1'b0, 8'h00},   // R3 copy
      '{8'h60, 8'd20, 1'b1, 1'b0, 8'h00},   // R4 match
      '{8'h60, 8'd21, 1'b1, 1'b0, 8'h00},   // R4 miss
      '{8'h81, 8'd3,  1'b1, 1'b0, 8'h00},   // R5 erase
      '{8'h83, 8'd22, 1'b1, 1'b1, 8'h5A},   // R6 erase+program
      '{8'h88, 8'd3,  1'b1, 1'b1, 8'hC3},   // R7 program erased page
      '{8'h88, 8'd22, 1'b1, 1'b1, 8'h0F},   // R7 AND merge
      '{8'h50, 8'd27, 1'b1, 1'b0, 8'h00},   // R8 group erase 24..31
      '{8'h58, 8'd5,  1'b1, 1'b1, 8'h77},   // R9 rewrite
      '{8'h82, 8'd9,  1'b0, 1'b1, 8'h11},   // R10 blocked
      '{8'h50, 8'd2,  1'b0, 1'b0, 8'h00},   // R10 blocked group
      '{8'h83, 8'd17, 1'b0, 1'b1, 8'h22},   // R10 upper half allowed
      '{8'h53, 8'd1,  1'b0, 1'b0, 8'h00},   // R10 copy allowed when guarded
      '{8'h60, 8'd1,  1'b0, 1'b0, 8'h00},   // R4 match clears sticky bit
      '{8'h57, 8'd0,  1'b1, 1'b0, 8'h00}    // R2 non-busy opcode
   };

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired (R2) actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int n;
      bit runs;
      exp_cmp = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R11: reset state
      check(status == 8'h88, "R1 status after reset", status, 8'h88);
      check(rdy_busy_n == 1'b1, "R11 ready after reset", rdy_busy_n, 1);
      init_mem();
      load_buf(8'h00);

      for (int v = 0; v < NV; v++) begin
         string tag;
         tag = $sformatf("vec%0d op=%02h", v, VECS[v].op);
         if (VECS[v].ld) load_buf(VECS[v].seed);
         runs = ref_apply(VECS[v].op, int'(VECS[v].page), VECS[v].wp);
         pulse_cmd(VECS[v].op, int'(VECS[v].page), VECS[v].wp);
         check(rdy_busy_n == !runs, {tag, " R2/R10 busy after accept"}, rdy_busy_n, !runs);
         wait_ready(n);
         check(n == (runs ? exp_cycles(VECS[v].op) : 0), {tag, " R2 busy length"}, n,
               runs ? exp_cycles(VECS[v].op) : 0);
         check_arrays({tag, " R3-R10"});
         check(status == {1'b1, exp_cmp, 6'b001000}, {tag, " R1/R4 status"}, status,
               {1'b1, exp_cmp, 6'b001000});
      end

      // R12: a command pulse during busy is ignored
      wp_n = 1'b1;
      load_buf(8'h3C);
      runs = ref_apply(8'h83, 18, 1'b1);
      pulse_cmd(8'h83, 18, 1'b1);
      pulse_cmd(8'h81, 19, 1'b1);
      wait_ready(n);
      check(n > 0, "R12 still busy after second pulse", n, 1);
      check_arrays("R12 ignored command");

      // R11: abort a compound operation with reset
      load_buf(8'h99);
      pulse_cmd(8'h58, 30, 1'b1);
      repeat (6) @(negedge clk);
      check(rdy_busy_n == 1'b0, "R11 busy before abort", rdy_busy_n, 0);
      rst_n = 1'b0;
      @(negedge clk);
      check(rdy_busy_n == 1'b1, "R11 ready during reset", rdy_busy_n, 1);
      check(status == 8'h88, "R11 status during reset", status, 8'h88);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rdy_busy_n == 1'b1, "R11 ready after release", rdy_busy_n, 1);
      exp_cmp = 1'b0;
      init_mem();
      load_buf(8'h44);
      runs = ref_apply(8'h81, 30, 1'b1);
      pulse_cmd(8'h81, 30, 1'b1);
      check(rdy_busy_n == 1'b0, "R11 accepts after release", rdy_busy_n, 0);
      wait_ready(n);
      check(n == exp_cycles(8'h81), "R11 R5 busy length after release", n, exp_cycles(8'h81));
      check_arrays("R11 R5 erase after release");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule